// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block conditions four external interrupt pins before they reach an interrupt controller. Each pin first passes through a two-flop synchroniser into the core clock domain. Each channel then runs a small state machine that keeps a sticky or level-following flag. The flag drives the channel's request line.

Software configures every channel through a small register port. One register picks level or edge sensitivity. A second register picks the active sense: high level or rising edge, or low level or falling edge. A third register shows the flags, and writing ones to it clears them. A change of mode or sense can raise a false event, so software is expected to write-one-clear the affected flag right after it reconfigures a channel.

Each channel has three states:
- QUIET: the flag is clear.
- HELD: level mode with the active level present; the flag is set.
- LATCHED: an edge was captured; the flag is set.

The transitions are:
- QUIET to HELD when the channel is in level mode and the level is active.
- QUIET to LATCHED when the channel is in edge mode and an edge is seen.
- HELD to QUIET when the level goes inactive.
- HELD to LATCHED when the channel is switched to edge mode.
- LATCHED to QUIET on a clear.
- LATCHED to HELD on a clear while the channel is in level mode and the level is active.
- LATCHED stays LATCHED on a clear when an edge is seen in that same cycle.

Top module: `extint_conditioner`

## Requirements
- R1: After reset, all channels are level-sensitive and active-low, all flags read 0, and `irq_req` is 0.
- R2: Register addresses are fixed. Address 0 is mode, address 1 is polarity, address 2 is flag, and address 3 reads as 0. Bit i of each register belongs to channel i. Mode and polarity read back the last value written to them.
- R3: In the mode register, a bit of 0 selects level sensitivity and 1 selects edge sensitivity. In the polarity register, 1 selects high level or rising edge and 0 selects low level or falling edge. An edge of the opposite sense sets no flag.
- R4: Each pin is sampled by two flops before detection. A pin change made before rising clock edge k shows on `irq_req` after edge k+2 and not earlier.
- R5: In level mode the flag follows the active level. A clear write has no effect while the level is still active.
- R6: In edge mode a detected edge sets the flag. The flag stays set after the pin returns to idle, until it is cleared.
- R7: Writing to the flag register clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R8: If a clear and a new edge on the same channel land in the same cycle, the flag stays set.
- R9: Flipping the polarity of an edge-mode channel, with the pin idle, can set a false flag. A write-one clear removes it.
- R10: `irq_req[i]` always equals flag bit i as read at address 2.
- R11: Channels are independent. An event on one channel sets no other channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 4 | Register read data (combinational) |
| irq_req | output | 4 | Request lines to the interrupt controller |

## Verification
Two functions can fall in the same cycle: a write-one clear of a flag, and a fresh edge on that same channel. The bench first leaves the flag set. It then drives a new rising edge on the pin and times the clear write so that it lands on exactly the clock edge where the synchronised edge is detected. Both events then hit the state register together. The result is judged correct only if the flag is still set afterwards. A second, lone clear must then remove it.

// File: rtl/extc_pkg.sv
package extc_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] A_POL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_HELD    = 2'd1,
        ST_LATCHED = 2'd2
    } chan_state_e;
endpackage

// File: rtl/extc_sync.sv
module extc_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {WIDTH{RST_VAL}};
            stage2 <= {WIDTH{RST_VAL}};
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/extc_regs.sv
module extc_regs
    import extc_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NCH-1:0]    wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NCH-1:0]    flags,
    output logic [NCH-1:0]    rd_data,
    output logic [NCH-1:0]    mode_edge,
    output logic [NCH-1:0]    pol_high,
    output logic [NCH-1:0]    clr_pulse
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_edge <= '0;
            pol_high  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MODE) mode_edge <= wr_data;
            if (wr_addr == A_POL)  pol_high  <= wr_data;
        end
    end

    always_comb begin
        clr_pulse = '0;
        if (wr_en && wr_addr == A_FLAG) clr_pulse = wr_data;
    end

    always_comb begin
        unique case (rd_addr)
            A_MODE:  rd_data = mode_edge;
            A_POL:   rd_data = pol_high;
            A_FLAG:  rd_data = flags;
            default: rd_data = '0;
        endcase
    end

    p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE) |=> (mode_edge == $past(wr_data)));
endmodule

// File: rtl/extc_channel.sv
module extc_channel
    import extc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    input  logic edge_mode,
    input  logic act_high,
    input  logic clr,
    output logic flag
);
    chan_state_e st_q, st_d;
    logic act, act_prev, edge_ev;

    assign act     = act_high ? pin_sync : ~pin_sync;
    assign edge_ev = act & ~act_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_prev <= 1'b0;
        else        act_prev <= act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: begin
                if (edge_mode && edge_ev)    st_d = ST_LATCHED;
                else if (!edge_mode && act)  st_d = ST_HELD;
            end
            ST_HELD: begin
                if (edge_mode)               st_d = ST_LATCHED;
                else if (!act)               st_d = ST_QUIET;
            end
            ST_LATCHED: begin
                if (clr) begin
                    if (edge_mode && edge_ev)    st_d = ST_LATCHED;
                    else if (!edge_mode && act)  st_d = ST_HELD;
                    else                         st_d = ST_QUIET;
                end
            end
            default: st_d = ST_QUIET;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_HELD, ST_LATCHED: flag = 1'b1;
            default:             flag = 1'b0;
        endcase
    end

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCHED && !clr) |=> flag);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCHED && clr && !(edge_mode && edge_ev) && !(!edge_mode && act)) |=> !flag);
    p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && edge_mode && edge_ev) |=> flag);
    p_level_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && act) |=> flag);
    p_level_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD && !edge_mode && !act) |=> !flag);
endmodule

// File: rtl/extint_conditioner.sv
module extint_conditioner
    import extc_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NCH-1:0]    wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NCH-1:0]    rd_data,
    output logic [NCH-1:0]    irq_req
);
    logic [NCH-1:0] pin_s, mode_edge, pol_high, clr_pulse, flags;

    extc_sync #(.WIDTH(NCH), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_s)
    );

    extc_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .flags(flags),
        .rd_data(rd_data), .mode_edge(mode_edge), .pol_high(pol_high),
        .clr_pulse(clr_pulse)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        extc_channel u_ch (
            .clk(clk), .rst_n(rst_n), .pin_sync(pin_s[i]),
            .edge_mode(mode_edge[i]), .act_high(pol_high[i]),
            .clr(clr_pulse[i]), .flag(flags[i])
        );
    end

    assign irq_req = flags;

    p_req_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_FLAG) |-> (rd_data == irq_req));
endmodule

// File: tb/tb_extint_conditioner.sv
`timescale 1ns/1ps
module tb_extint_conditioner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = 4'hF;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [3:0] rd_data, irq_req;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    extint_conditioner dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [3:0] v;
        rd(2'd0, v); check("R1 mode", v, 4'b0000);
        rd(2'd1, v); check("R1 pol", v, 4'b0000);
        rd(2'd2, v); check("R1 flag", v, 4'b0000);
        check("R1 irq", irq_req, 4'b0000);
    endtask

    task automatic t_regs;
        logic [3:0] v;
        wr(2'd0, 4'b0100); rd(2'd0, v); check("R2 mode readback", v, 4'b0100);
        wr(2'd1, 4'b0000); rd(2'd1, v); check("R2 pol readback", v, 4'b0000);
        rd(2'd3, v); check("R2 unmapped", v, 4'b0000);
    endtask

    task automatic t_level;
        logic [3:0] v;
        @(negedge clk); pin_in[0] = 1'b0;
        cyc(2); check("R4 not yet", irq_req, 4'b0000);
        cyc(1); check("R4 third edge", irq_req, 4'b0001);
        wr(2'd2, 4'b0001); cyc(1);
        rd(2'd2, v); check("R5 clear ignored while active", v, 4'b0001);
        check("R10 irq mirrors flag", irq_req, v);
        @(negedge clk); pin_in[0] = 1'b1;
        cyc(4); check("R5 level drop", irq_req, 4'b0000);
    endtask

    task automatic t_edge;
        @(negedge clk); pin_in[2] = 1'b0;
        cyc(4); check("R6 falling edge sets", irq_req, 4'b0100);
        @(negedge clk); pin_in[2] = 1'b1;
        cyc(4); check("R6 stays after idle", irq_req, 4'b0100);
        wr(2'd2, 4'b1011); cyc(1); check("R7 zero bit kept", irq_req, 4'b0100);
        wr(2'd2, 4'b0100); cyc(1); check("R7 one bit clears", irq_req, 4'b0000);
    endtask

    task automatic t_reconfig;
        wr(2'd0, 4'b1100);
        wr(2'd1, 4'b1000); cyc(2);
        check("R9 polarity flip false flag", irq_req, 4'b1000);
        wr(2'd2, 4'b1000); cyc(1); check("R9 false flag cleared", irq_req, 4'b0000);
        @(negedge clk); pin_in[3] = 1'b0;
        cyc(4); check("R3 falling ignored when rising set", irq_req, 4'b0000);
        @(negedge clk); pin_in[3] = 1'b1;
        cyc(4); check("R3 rising sets", irq_req[3], 1'b1);
        check("R11 only channel 3", irq_req, 4'b1000);
    endtask

    task automatic t_collide;
        @(negedge clk); pin_in[3] = 1'b0;
        cyc(4); check("R8 precondition", irq_req, 4'b1000);
        @(negedge clk); pin_in[3] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 4'b1000;
        @(negedge clk); wr_en = 1'b0;
        check("R8 edge wins over clear", irq_req, 4'b1000);
        wr(2'd2, 4'b1000); cyc(1); check("R8 lone clear", irq_req, 4'b0000);
    endtask

    initial begin
        #20000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        cyc(4);
        check("R1 after release", irq_req, 4'b0000);
        t_regs();
        t_level();
        t_edge();
        t_reconfig();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule